// File: doc/BRIEF.md
# Policy-Selectable Data Cache Controller

This block is a small direct-mapped data cache. It sits between a processor load/store port and a single-word backing memory port. Two static configuration pins pick its behaviour. The first pin selects what a store hit does: the store either updates the line and memory together, or it updates only the line and marks the line dirty. The second pin selects what a store miss does: the controller either fetches the whole line and then writes into it, or it sends the store straight to memory and leaves the cache untouched.

Every store that must reach memory outside of an eviction goes through a small FIFO of address/data pairs. The processor therefore waits only when that FIFO is already full. Before any line fetch, the FIFO is emptied completely, so a fetch can never read a memory word that an earlier store has not yet reached. A dirty victim is written out word by word before the replacement line is requested.

The processor holds `cpuReq` and its operands until `cpuReady` is high for one cycle. The memory side holds `memReq`, `memWe`, `memAddr` and `memWdata` until `memAck` is high for one cycle, and each acknowledge moves one word. The configuration pins are changed only while reset is held. All addresses are word addresses.

Top module: `dc_top`

## Requirements
- R1: A load that hits completes in the cycle it is presented: `cpuReady` is high in that cycle, `cpuRdata` carries the cached word, and no memory transaction is issued.
- R2: A load miss reads the four words of its line from memory, from line base + 0 up to base + 3 in ascending order. The load then completes with the word at the requested address.
- R3: With `cfgWriteBack`=0, a store hit completes in one cycle and updates the cached word. Exactly one memory write of that word and address follows through the store buffer.
- R4: With `cfgWriteBack`=1, a store hit completes in one cycle, updates only the cached word, and issues no memory transaction.
- R5: A miss that replaces a valid dirty line first writes the four victim words to memory in ascending order, and only then issues the four refill reads.
- R6: With `cfgWriteAlloc`=1, a store miss refills the line from memory and then writes the store into the cache. The other words of the line come from memory, and later loads to the line hit.
- R7: With `cfgWriteAlloc`=0, a store miss issues one memory write of that word and changes no cache line. A resident line at the same index keeps hitting, and a later load of the stored address misses.
- R8: The store buffer holds 4 entries and drains them to memory in arrival order. A store that needs it completes in one cycle while it has room, and stalls only while it is full.
- R9: A line refill starts only after the store buffer is empty, so a load miss returns the value of the most recent store to that address.
- R10: While `memReq` is high without `memAck`, the request, its address, direction and write data stay unchanged in the next cycle.
- R11: After reset no line is valid and `memReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWriteBack | input | 1 | 1: store hit updates only the line; 0: line and memory |
| cfgWriteAlloc | input | 1 | 1: store miss fetches the line; 0: store miss goes to memory only |
| cpuReq | input | 1 | Processor access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 store, 0 load |
| cpuAddr | input | AW (12) | Word address |
| cpuWdata | input | DW (32) | Store data |
| cpuReady | output | 1 | Access completes in this cycle |
| cpuRdata | output | DW (32) | Load data, valid with `cpuReady` |
| memReq | output | 1 | Memory request, held until `memAck` |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | AW (12) | Memory word address |
| memWdata | output | DW (32) | Memory write data |
| memAck | input | 1 | One-cycle acknowledge of the current beat |
| memRdata | input | DW (32) | Read data, valid with `memAck` |

## Verification
The bench runs all four policy pairings. Each pairing gets its own sequence of loads and stores that hit, miss a clean line, and miss a dirty line. The logged memory traffic, meaning the direction, address and order of every beat, tells write-through from write-back, write-allocate from write-around, and a clean replacement from an eviction followed by a refill. Store completion times are measured under a slow memory, which separates a buffered store from a store stalled on a full buffer. A load miss is issued right behind a buffered store to the same address, which shows whether the refill waits for the buffer to drain or reads stale memory.

// File: rtl/dc_pkg.sv
package dc_pkg;
  // strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic cpuWr;     // write processor word into the line
    logic markDirty; // set dirty bit of the indexed line
    logic fillWr;    // write one refill beat into the line
    logic fillDone;  // last refill beat: install tag, valid, clean
    logic evictSel;  // memory address built from the stored tag
  } dc_strobe_t;
endpackage

// File: rtl/dc_wbuf.sv
module dc_wbuf #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [AW-1:0] pushAddr,
  input  logic [DW-1:0] pushData,
  input  logic          ack,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [PW-1:0] wrP, rdP;
  logic [PW:0]   cnt;
  logic          pop;

  assign empty    = (cnt == '0);
  assign full     = (cnt == (PW+1)'(DEPTH));
  assign pop      = ack && !empty;
  assign headAddr = addrQ[rdP];
  assign headData = dataQ[rdP];

  always_ff @(posedge clk) begin
    if (push) begin
      addrQ[wrP] <= pushAddr;
      dataQ[wrP] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrP <= '0;
      rdP <= '0;
      cnt <= '0;
    end else begin
      if (push) wrP <= wrP + 1'b1;
      if (pop)  rdP <= rdP + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  a_r8_ack_has_entry: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> !empty);
endmodule

// File: rtl/dc_datapath.sv
module dc_datapath
  import dc_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dc_strobe_t                    ctl,
  input  logic [AW-1:0]                 cpuAddr,
  input  logic [DW-1:0]                 cpuWdata,
  input  logic [$clog2(LINE_WORDS)-1:0] beat,
  input  logic [DW-1:0]                 memRdata,
  output logic                          hit,
  output logic                          victimDirty,
  output logic [DW-1:0]                 rdWord,
  output logic [DW-1:0]                 evictWord,
  output logic [AW-1:0]                 lineAddr
);
  localparam int OW = $clog2(LINE_WORDS);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - OW - IW;
  localparam int NW = LINES * LINE_WORDS;

  logic [DW-1:0]    dataQ [NW];
  logic [TW-1:0]    tagQ  [LINES];
  logic [LINES-1:0] validQ, dirtyQ;

  logic [OW-1:0] off;
  logic [IW-1:0] idx;
  logic [TW-1:0] tag;

  assign off = cpuAddr[OW-1:0];
  assign idx = cpuAddr[OW +: IW];
  assign tag = cpuAddr[AW-1 -: TW];

  assign hit         = validQ[idx] && (tagQ[idx] == tag);
  assign victimDirty = validQ[idx] && dirtyQ[idx];
  assign rdWord      = dataQ[{idx, off}];
  assign evictWord   = dataQ[{idx, beat}];
  assign lineAddr    = ctl.evictSel ? {tagQ[idx], idx, beat} : {tag, idx, beat};

  always_ff @(posedge clk) begin
    if (ctl.cpuWr)  dataQ[{idx, off}]  <= cpuWdata;
    if (ctl.fillWr) dataQ[{idx, beat}] <= memRdata;
    if (ctl.fillDone) tagQ[idx] <= tag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (ctl.fillDone) begin
      validQ[idx] <= 1'b1;
      dirtyQ[idx] <= 1'b0;
    end else if (ctl.markDirty) begin
      dirtyQ[idx] <= 1'b1;
    end
  end

  // R6 / R2: once the last beat lands, the held address hits
  a_r6_fill_then_hit: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillDone |=> hit);
  // R11: nothing is valid in the first cycle after reset
  a_r11_reset_empty: assert property (@(posedge clk)
    !rstN |=> !hit);
endmodule

// File: rtl/dc_control.sv
module dc_control
  import dc_pkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWriteBack,
  input  logic                          cfgWriteAlloc,
  input  logic                          cpuReq,
  input  logic                          cpuWe,
  input  logic                          hit,
  input  logic                          victimDirty,
  input  logic                          wbFull,
  input  logic                          wbEmpty,
  input  logic                          memAck,
  output dc_strobe_t                    ctl,
  output logic [$clog2(LINE_WORDS)-1:0] beat,
  output logic                          cpuReady,
  output logic                          wbPush,
  output logic                          ownMem,
  output logic                          ctlMemWe
);
  localparam int OW = $clog2(LINE_WORDS);
  localparam logic [OW-1:0] LAST = OW'(LINE_WORDS - 1);

  typedef enum logic [1:0] {IDLE, DRAIN, EVICT, REFILL} state_t;
  state_t stateQ, stateD;
  logic [OW-1:0] beatQ;

  assign beat = beatQ;

  always_comb begin
    stateD   = stateQ;
    ctl      = '0;
    cpuReady = 1'b0;
    wbPush   = 1'b0;
    ownMem   = 1'b0;
    ctlMemWe = 1'b0;
    case (stateQ)
      IDLE: if (cpuReq) begin
        if (!cpuWe) begin
          if (hit) cpuReady = 1'b1;
          else     stateD   = DRAIN;
        end else if (hit) begin
          if (cfgWriteBack) begin
            ctl.cpuWr     = 1'b1;
            ctl.markDirty = 1'b1;
            cpuReady      = 1'b1;
          end else if (!wbFull) begin
            ctl.cpuWr = 1'b1;
            wbPush    = 1'b1;
            cpuReady  = 1'b1;
          end
        end else if (cfgWriteAlloc) begin
          stateD = DRAIN;
        end else if (!wbFull) begin
          wbPush   = 1'b1;
          cpuReady = 1'b1;
        end
      end
      DRAIN: if (wbEmpty) stateD = victimDirty ? EVICT : REFILL;
      EVICT: begin
        ownMem       = 1'b1;
        ctlMemWe     = 1'b1;
        ctl.evictSel = 1'b1;
        if (memAck && beatQ == LAST) stateD = REFILL;
      end
      REFILL: begin
        ownMem = 1'b1;
        if (memAck) begin
          ctl.fillWr = 1'b1;
          if (beatQ == LAST) begin
            ctl.fillDone = 1'b1;
            stateD       = IDLE;
          end
        end
      end
      default: stateD = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= IDLE;
      beatQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (ownMem && memAck) beatQ <= beatQ + 1'b1;
    end
  end

  // R9: the controller uses the memory port only with an empty buffer
  a_r9_fill_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    ownMem |-> wbEmpty);
  // R5: the last eviction beat hands over to the refill
  a_r5_evict_then_refill: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == EVICT && memAck && beatQ == LAST) |=> (stateQ == REFILL && beatQ == '0));
  // R1: completion is only ever signalled for a presented access
  a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);
endmodule

// File: rtl/dc_top.sv
module dc_top
  import dc_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 8,
  parameter int WB_DEPTH   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWriteBack,
  input  logic          cfgWriteAlloc,
  input  logic          cpuReq,
  input  logic          cpuWe,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuReady,
  output logic [DW-1:0] cpuRdata,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata
);
  localparam int OW = $clog2(LINE_WORDS);

  dc_strobe_t    ctl;
  logic [OW-1:0] beat;
  logic          hit, victimDirty, wbPush, ownMem, ctlMemWe;
  logic          wbFull, wbEmpty;
  logic [DW-1:0] evictWord, wbData;
  logic [AW-1:0] lineAddr, wbAddr;

  dc_control #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWriteBack(cfgWriteBack), .cfgWriteAlloc(cfgWriteAlloc),
    .cpuReq(cpuReq), .cpuWe(cpuWe),
    .hit(hit), .victimDirty(victimDirty),
    .wbFull(wbFull), .wbEmpty(wbEmpty), .memAck(memAck),
    .ctl(ctl), .beat(beat), .cpuReady(cpuReady),
    .wbPush(wbPush), .ownMem(ownMem), .ctlMemWe(ctlMemWe)
  );

  dc_datapath #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS), .LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .beat(beat), .memRdata(memRdata),
    .hit(hit), .victimDirty(victimDirty),
    .rdWord(cpuRdata), .evictWord(evictWord), .lineAddr(lineAddr)
  );

  dc_wbuf #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rstN(rstN),
    .push(wbPush), .pushAddr(cpuAddr), .pushData(cpuWdata),
    .ack(memAck && !ownMem),
    .full(wbFull), .empty(wbEmpty),
    .headAddr(wbAddr), .headData(wbData)
  );

  assign memReq   = ownMem ? 1'b1      : !wbEmpty;
  assign memWe    = ownMem ? ctlMemWe  : 1'b1;
  assign memAddr  = ownMem ? lineAddr  : wbAddr;
  assign memWdata = ownMem ? evictWord : wbData;

  // R10: a pending beat is held unchanged until acknowledged
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)
                             && (!memWe || $stable(memWdata))));
  // R11: no memory request right after reset
  a_r11_idle_after_reset: assert property (@(posedge clk)
    !rstN |=> !memReq);
endmodule

// File: tb/tb_dc_top.sv
module tb_dc_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int MEMW = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWriteBack = 1'b0, cfgWriteAlloc = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic cpuReady;
  logic [DW-1:0] cpuRdata;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic memAck = 1'b0;
  logic [DW-1:0] memRdata = '0;

  always #2 clk = ~clk;

  dc_top dut (
    .clk(clk), .rstN(rstN), .cfgWriteBack(cfgWriteBack), .cfgWriteAlloc(cfgWriteAlloc),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] initPat(input int a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0000_9E37);
  endfunction

  // backing memory model with programmable latency and a traffic log
  logic [DW-1:0] mem [MEMW];
  logic [DW-1:0] refMem [MEMW];
  bit memInit = 1'b0;
  int memLat = 2;
  int waitCnt = 0;
  bit logWe [$];
  int logAddr [$];

  always @(posedge clk) begin
    if (!memInit) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= initPat(i);
      memInit <= 1'b1;
    end
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      if (waitCnt >= memLat) begin
        memAck  <= 1'b1;
        waitCnt <= 0;
        if (memWe) mem[memAddr] <= memWdata;
        else       memRdata     <= mem[memAddr];
        logWe.push_back(memWe);
        logAddr.push_back(int'(memAddr));
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard: driver queues expected load data, monitor compares
  logic [DW-1:0] expQ [$];
  string tagQ [$];

  always @(negedge clk) begin
    if (rstN && cpuReq && cpuReady && !cpuWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected load completion", cpuRdata, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(cpuRdata == e, t, cpuRdata, e);
      end
    end
  end

  task automatic access(input bit we, input int addr, input logic [DW-1:0] data,
                        input string tag, output int cyc);
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = AW'(addr); cpuWdata = data;
    if (we) refMem[addr] = data;
    else begin
      expQ.push_back(refMem[addr]);
      tagQ.push_back(tag);
    end
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cpuReady) break;
    end
    @(posedge clk); #1;
    cpuReq = 1'b0;
  endtask

  task automatic doReset(input bit wb, input bit wa);
    @(posedge clk); #1;
    rstN = 1'b0; cfgWriteBack = wb; cfgWriteAlloc = wa;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic waitDrain();
    repeat (2) @(negedge clk);
    while (memReq) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc, base, n, wr;
    int c [5];
    for (int i = 0; i < MEMW; i++) refMem[i] = initPat(i);

    // write-through, write-allocate
    memLat = 2;
    doReset(1'b0, 1'b1);
    @(negedge clk);
    check(memReq == 1'b0, "R11 memReq after reset", 32'(memReq), 0);

    base = logAddr.size();
    access(1'b0, 'h010, '0, "R2 load miss data", cyc);
    n = logAddr.size() - base;
    check(n == 4, "R2 refill beats", n, 4);
    for (int i = 0; i < 4; i++)
      if (base + i < logAddr.size())
        check(!logWe[base+i] && logAddr[base+i] == 'h010 + i, "R2 refill order",
              logAddr[base+i], 'h010 + i);

    base = logAddr.size();
    access(1'b0, 'h012, '0, "R1 load hit data", cyc);
    check(cyc == 1, "R1 hit latency", cyc, 1);
    check(logAddr.size() == base, "R1 hit no traffic", logAddr.size() - base, 0);

    base = logAddr.size();
    access(1'b1, 'h011, 32'h1111_0001, "", cyc);
    check(cyc == 1, "R3 store hit latency", cyc, 1);
    waitDrain();
    n = logAddr.size() - base;
    check(n == 1, "R3 one memory write", n, 1);
    if (n >= 1) check(logWe[base] && logAddr[base] == 'h011, "R3 write address", logAddr[base], 'h011);
    check(mem['h011] == 32'h1111_0001, "R3 memory updated", mem['h011], 32'h1111_0001);
    access(1'b0, 'h011, '0, "R3 cache updated", cyc);

    // buffer capacity under a slow memory
    memLat = 20;
    for (int i = 0; i < 5; i++) access(1'b1, 'h010 + (i % 4), 32'h2200_0000 + 32'(i), "", c[i]);
    for (int i = 0; i < 4; i++) check(c[i] == 1, "R8 buffered store latency", c[i], 1);
    check(c[4] > 5, "R8 stall when full", c[4], 6);
    waitDrain();
    check(mem['h010] == 32'h2200_0004, "R8 in-order drain", mem['h010], 32'h2200_0004);
    check(mem['h013] == 32'h2200_0003, "R8 drain content", mem['h013], 32'h2200_0003);

    // write-through, write-around
    memLat = 3;
    doReset(1'b0, 1'b0);
    access(1'b0, 'h012, '0, "R2 reload", cyc);
    memLat = 20;
    base = logAddr.size();
    access(1'b1, 'h310, 32'h3333_0310, "", cyc);
    check(cyc == 1, "R7 around store latency", cyc, 1);
    access(1'b0, 'h012, '0, "R7 resident line kept", cyc);
    check(cyc == 1, "R7 resident line still hits", cyc, 1);
    access(1'b0, 'h310, '0, "R9 load after buffered store", cyc);
    n = logAddr.size() - base;
    check(n == 5, "R7 around write then refill beats", n, 5);
    if (n >= 1) check(logWe[base] && logAddr[base] == 'h310, "R9 buffered write first",
                      logAddr[base], 'h310);
    memLat = 2;
    waitDrain();

    // write-back, write-allocate
    doReset(1'b1, 1'b1);
    access(1'b0, 'h040, '0, "R2 load miss wb", cyc);
    base = logAddr.size();
    access(1'b1, 'h041, 32'h4444_0041, "", cyc);
    check(cyc == 1, "R4 store hit latency", cyc, 1);
    repeat (20) @(negedge clk);
    check(logAddr.size() == base, "R4 no memory traffic", logAddr.size() - base, 0);
    check(mem['h041] == initPat('h041), "R4 memory untouched", mem['h041], initPat('h041));
    access(1'b0, 'h041, '0, "R4 cache holds store", cyc);

    base = logAddr.size();
    access(1'b0, 'h240, '0, "R5 load after eviction", cyc);
    n = logAddr.size() - base;
    check(n == 8, "R5 evict plus refill beats", n, 8);
    if (n == 8)
      for (int i = 0; i < 4; i++) begin
        check(logWe[base+i] && logAddr[base+i] == 'h040 + i, "R5 victim write order",
              logAddr[base+i], 'h040 + i);
        check(!logWe[base+4+i] && logAddr[base+4+i] == 'h240 + i, "R5 refill after evict",
              logAddr[base+4+i], 'h240 + i);
      end
    check(mem['h041] == 32'h4444_0041, "R5 dirty word written", mem['h041], 32'h4444_0041);

    base = logAddr.size();
    access(1'b1, 'h0A2, 32'h5555_00A2, "", cyc);
    n = logAddr.size() - base;
    wr = 0;
    for (int i = base; i < logAddr.size(); i++) if (logWe[i]) wr++;
    check(n == 4 && wr == 0, "R6 allocate refill only", n, 4);
    check(mem['h0A2] == initPat('h0A2), "R6 memory not written", mem['h0A2], initPat('h0A2));
    base = logAddr.size();
    access(1'b0, 'h0A3, '0, "R6 neighbour from memory", cyc);
    access(1'b0, 'h0A2, '0, "R6 store in cache", cyc);
    check(logAddr.size() == base, "R6 later loads hit", logAddr.size() - base, 0);

    // write-back, write-around
    doReset(1'b1, 1'b0);
    base = logAddr.size();
    access(1'b1, 'h500, 32'h6666_0500, "", cyc);
    waitDrain();
    n = logAddr.size() - base;
    check(n == 1, "R7 around single write", n, 1);
    check(mem['h500] == 32'h6666_0500, "R7 memory written", mem['h500], 32'h6666_0500);
    base = logAddr.size();
    access(1'b0, 'h500, '0, "R7 load after around", cyc);
    check(logAddr.size() - base == 4, "R7 cache was not filled", logAddr.size() - base, 4);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R1 scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule